// File: doc/BRIEF.md
# Mute and Calibration Sequencer

This block decides when the two audio outputs of a volume stage are cut off from their amplifiers and grounded, and when they are reconnected. It reacts to an active-low hardware mute pin, a supply-good flag, one zero-cross event per channel and a millisecond tick. On a mute request it asks each channel to disconnect at that channel's next zero crossing, with a fixed timeout as a fallback. It also starts an offset calibration and holds the mute until that calibration is complete.

When the supply drops, both outputs are grounded at once. When the supply comes back, and also after reset, the block runs a power-up sequence. That sequence first sends a one-cycle command to clear the serial and volume registers. It then sends a one-cycle calibration start. Both outputs stay grounded until the mute pin is released and the calibration has finished. Software mute by volume code, the analog calibration itself and the output termination are handled by other blocks.

Top module: `mute_cal_seq`

## Requirements
- R1: The mute pin and the supply-good input each pass through two synchronizing flops, so a change on either pin affects the outputs on the third rising clock edge after it.
- R2: A falling edge on the mute pin, while the supply is good, produces a `cal_start` pulse exactly one cycle wide.
- R3: After a mute request, channel c disconnects (`out_disc[c]`=1) on the edge that samples its first `zc_evt[c]`. A zero-cross event is ignored while no mute request is pending.
- R4: A channel that sees no zero crossing disconnects one cycle after TIMEOUT_MS (default 18) `ms_tick` pulses have been counted since the request, and not earlier.
- R5: With CAL_BY_DONE=0, calibration completes after CAL_MS (default 2) `ms_tick` pulses and `cal_done` is ignored. With CAL_BY_DONE=1, calibration completes on a `cal_done` pulse and ticks are ignored.
- R6: Both channels reconnect (`out_disc`=0) one cycle after all three conditions hold: mute pin released (high), supply good, calibration complete. Releasing the pin before calibration completes keeps the mute in force.
- R7: While the synchronized supply-good is low, both channels are disconnected without waiting for a zero crossing.
- R8: After reset or a supply recovery, `reg_clear` pulses for one cycle, then `cal_start` pulses in the next cycle. Both channels stay disconnected until the R6 conditions are met.
- R9: During reset, `out_disc` is all ones and `cal_start` and `reg_clear` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mute_n_pin | input | 1 | Hardware mute request, active low, asynchronous |
| supply_ok | input | 1 | Supply above threshold, asynchronous |
| zc_evt | input | NCH | Per-channel zero-cross event, one-cycle pulse |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| cal_done | input | 1 | Calibration finished pulse (used when CAL_BY_DONE=1) |
| out_disc | output | NCH | 1 = channel output disconnected and grounded |
| cal_start | output | 1 | One-cycle offset calibration start |
| reg_clear | output | 1 | One-cycle clear of shift and volume registers |

## Verification
A change on the mute or supply pin shows on the third rising edge after it. The bench checks for no change after two edges and for the new value after the third. Zero-cross, tick and done pulses are synchronous, so a disconnect caused by a zero crossing is seen one edge after the pulse. A reconnect, or a timeout disconnect, is seen one edge after the counting edge that completes its condition. Every check samples 1 ns after the relevant edge, or at the falling edge that ends a pulse. The bench never waits on an open-ended condition, so a result that arrives early or late fails its check.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  typedef enum logic [1:0] {
    SQ_DOWN = 2'd0,
    SQ_CLR  = 2'd1,
    SQ_MUTE = 2'd2,
    SQ_RUN  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/mcs_sync2.sv
module mcs_sync2 #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg1_q, stg2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= '0;
      stg2_q <= '0;
    end else begin
      stg1_q <= d;
      stg2_q <= stg1_q;
    end
  end

  assign q = stg2_q;
endmodule

// File: rtl/mcs_sat_cnt.sv
module mcs_sat_cnt #(
  parameter int LIMIT = 18
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic step,
  output logic hit
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign hit = (cnt_q == LIM_V);

  always_comb begin
    cnt_en = restart | (step & ~hit);
    cnt_d  = restart ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/mcs_chan_gate.sv
module mcs_chan_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic force_off,
  input  logic release_i,
  input  logic zc,
  input  logic tmo,
  output logic disc
);
  logic pend_q, pend_d;
  logic disc_q, disc_d;

  always_comb begin
    pend_d = pend_q;
    disc_d = disc_q;
    if (pend_q && (zc || tmo)) begin
      disc_d = 1'b1;
      pend_d = 1'b0;
    end
    if (arm)       pend_d = 1'b1;
    if (force_off) disc_d = 1'b1;
    if (release_i) begin
      disc_d = 1'b0;
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      disc_q <= 1'b1;
    end else begin
      pend_q <= pend_d;
      disc_q <= disc_d;
    end
  end

  assign disc = disc_q;
endmodule

// File: rtl/mute_cal_seq.sv
module mute_cal_seq
  import mcs_pkg::*;
#(
  parameter int NCH         = 2,
  parameter int TIMEOUT_MS  = 18,
  parameter int CAL_MS      = 2,
  parameter bit CAL_BY_DONE = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mute_n_pin,
  input  logic           supply_ok,
  input  logic [NCH-1:0] zc_evt,
  input  logic           ms_tick,
  input  logic           cal_done,
  output logic [NCH-1:0] out_disc,
  output logic           cal_start,
  output logic           reg_clear
);
  localparam int CAL_LIM = CAL_BY_DONE ? 1 : CAL_MS;

  logic [1:0]  sync_q;
  logic        mute_s, sup_s, mute_q;
  logic        mute_fall, go_mute, in_mute, release_all, force_all;
  logic        cal_evt, cal_ok, tmo_hit, tmo_live;
  logic        cal_start_q;
  seq_state_e  state_q, state_d;

  mcs_sync2 #(.W(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({mute_n_pin, supply_ok}),
    .q     (sync_q)
  );
  assign mute_s = sync_q[1];
  assign sup_s  = sync_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mute_q <= 1'b0;
    else        mute_q <= mute_s;
  end

  assign mute_fall = mute_q & ~mute_s;
  assign in_mute   = (state_q == SQ_MUTE);
  assign go_mute   = sup_s & ((state_q == SQ_CLR) ||
                     (((state_q == SQ_RUN) || in_mute) && mute_fall));
  assign release_all = in_mute & sup_s & mute_s & cal_ok & ~go_mute;
  assign force_all   = ~sup_s | (state_q == SQ_DOWN) | (state_q == SQ_CLR);
  assign cal_evt     = CAL_BY_DONE ? cal_done : ms_tick;

  always_comb begin
    state_d = state_q;
    if (!sup_s) begin
      state_d = SQ_DOWN;
    end else begin
      unique case (state_q)
        SQ_DOWN: state_d = SQ_CLR;
        SQ_CLR:  state_d = SQ_MUTE;
        SQ_MUTE: if (release_all) state_d = SQ_RUN;
        SQ_RUN:  if (go_mute)     state_d = SQ_MUTE;
        default: state_d = SQ_DOWN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= SQ_DOWN;
      cal_start_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      cal_start_q <= go_mute;
    end
  end

  mcs_sat_cnt #(.LIMIT(TIMEOUT_MS)) u_tmo (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (go_mute),
    .step    (in_mute & ms_tick),
    .hit     (tmo_hit)
  );

  mcs_sat_cnt #(.LIMIT(CAL_LIM)) u_cal (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (go_mute),
    .step    (in_mute & cal_evt),
    .hit     (cal_ok)
  );

  assign tmo_live = tmo_hit & in_mute;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    mcs_chan_gate u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .arm       (go_mute),
      .force_off (force_all),
      .release_i (release_all),
      .zc        (zc_evt[c]),
      .tmo       (tmo_live),
      .disc      (out_disc[c])
    );
  end

  assign cal_start = cal_start_q;
  assign reg_clear = (state_q == SQ_CLR);
endmodule

// File: rtl/mute_cal_seq_chk.sv
module mute_cal_seq_chk #(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           mute_s,
  input logic           sup_s,
  input logic           cal_start,
  input logic           reg_clear,
  input logic [NCH-1:0] out_disc
);
  // R7
  supply_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_s |=> (&out_disc));

  // R8
  clr_then_cal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_clear && sup_s) |=> cal_start);

  // R8
  clr_muted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_clear |-> (&out_disc));

  for (genvar c = 0; c < NCH; c++) begin : g_rc
    // R6
    reconnect_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(out_disc[c]) |-> ($past(mute_s) && $past(sup_s)));
  end
endmodule

bind mute_cal_seq mute_cal_seq_chk #(.NCH(NCH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mute_s    (mute_s),
  .sup_s     (sup_s),
  .cal_start (cal_start),
  .reg_clear (reg_clear),
  .out_disc  (out_disc)
);

// File: tb/sim_mute_cal_seq.sv
module sim_mute_cal_seq;
  logic       clk = 1'b0;
  logic       rst_n, mute_n_pin, supply_ok, ms_tick, cal_done;
  logic [1:0] zc_evt;
  logic [1:0] disc0, disc1;
  logic       cs0, cs1, rc0, rc1;
  int         n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  mute_cal_seq #(.NCH(2), .TIMEOUT_MS(18), .CAL_MS(2), .CAL_BY_DONE(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .mute_n_pin(mute_n_pin), .supply_ok(supply_ok),
    .zc_evt(zc_evt), .ms_tick(ms_tick), .cal_done(cal_done),
    .out_disc(disc0), .cal_start(cs0), .reg_clear(rc0));

  mute_cal_seq #(.NCH(2), .TIMEOUT_MS(18), .CAL_MS(2), .CAL_BY_DONE(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .mute_n_pin(mute_n_pin), .supply_ok(supply_ok),
    .zc_evt(zc_evt), .ms_tick(ms_tick), .cal_done(cal_done),
    .out_disc(disc1), .cal_start(cs1), .reg_clear(rc1));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic tick;
    @(negedge clk); ms_tick = 1'b1;
    @(negedge clk); ms_tick = 1'b0;
  endtask

  task automatic zc(input logic [1:0] m);
    @(negedge clk); zc_evt = m;
    @(negedge clk); zc_evt = 2'b00;
  endtask

  task automatic done_pulse;
    @(negedge clk); cal_done = 1'b1;
    @(negedge clk); cal_done = 1'b0;
  endtask

  task automatic set_mute(input logic v);
    @(negedge clk); mute_n_pin = v;
  endtask

  task automatic set_supply(input logic v);
    @(negedge clk); supply_ok = v;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mute_n_pin = 1'b0; supply_ok = 1'b1;
    ms_tick = 1'b0; cal_done = 1'b0; zc_evt = 2'b00;
    step(4);
    check("R9 disc in reset", disc0, 2'b11);
    check("R9 cal_start in reset", cs0, 1'b0);
    check("R9 reg_clear in reset", rc0, 1'b0);
    @(negedge clk); rst_n = 1'b1;

    // power-up with mute pin held low
    step(2);
    check("R1 R8 no clear before sync", rc0, 1'b0);
    step(1);
    check("R8 reg_clear pulse", rc0, 1'b1);
    check("R8 cal_start after clear", cs0, 1'b0);
    check("R8 muted during clear", disc0, 2'b11);
    step(1);
    check("R8 cal_start follows clear", cs0, 1'b1);
    check("R8 clear is one cycle", rc0, 1'b0);
    step(1);
    check("R2 cal_start one cycle", cs0, 1'b0);
    tick(); tick(); tick();
    check("R6 pin still low keeps mute", disc0, 2'b11);
    set_mute(1'b1);
    step(2);
    check("R1 R6 release not yet synced", disc0, 2'b11);
    step(1);
    check("R6 reconnect after release", disc0, 2'b00);
    check("R5 done mode ignores ticks", disc1, 2'b11);
    done_pulse();
    step(1);
    check("R5 done mode completes on cal_done", disc1, 2'b00);

    // zero crossing while running is ignored
    zc(2'b11);
    check("R3 zc ignored when not pending", disc0, 2'b00);

    // hardware mute: zc on ch0, timeout on ch1
    set_mute(1'b0);
    step(2);
    check("R1 R2 no pulse before sync", cs0, 1'b0);
    step(1);
    check("R2 cal_start on mute fall", cs0, 1'b1);
    check("R3 no disconnect before zc", disc0, 2'b00);
    step(1);
    check("R2 pulse width", cs0, 1'b0);
    zc(2'b01);
    check("R3 ch0 off at its zc", disc0, 2'b01);
    for (int i = 0; i < 17; i++) tick();
    check("R4 ch1 on before timeout", disc0, 2'b01);
    tick();
    check("R4 ch1 not early", disc0, 2'b01);
    step(1);
    check("R4 ch1 off at timeout", disc0, 2'b11);
    set_mute(1'b1);
    step(2);
    check("R6 still muted before sync", disc0, 2'b11);
    step(1);
    check("R6 unmute after calibration", disc0, 2'b00);

    // early release: cal_done ignored in count mode
    set_mute(1'b0);
    step(3);
    check("R2 second mute pulse", cs0, 1'b1);
    done_pulse();
    set_mute(1'b1);
    step(3);
    zc(2'b11);
    check("R5 R6 mute held, done ignored", disc0, 2'b11);
    tick();
    step(1);
    check("R6 one tick not enough", disc0, 2'b11);
    tick();
    check("R5 before release edge", disc0, 2'b11);
    step(1);
    check("R5 R6 reconnect after CAL_MS ticks", disc0, 2'b00);

    // supply drop and recovery
    set_supply(1'b0);
    step(2);
    check("R1 R7 drop not yet synced", disc0, 2'b00);
    step(1);
    check("R7 forced off without zc", disc0, 2'b11);
    step(5);
    check("R7 no clear while supply low", rc0, 1'b0);
    check("R7 still off", disc0, 2'b11);
    set_supply(1'b1);
    step(2);
    check("R8 no clear before sync", rc0, 1'b0);
    step(1);
    check("R8 clear on recovery", rc0, 1'b1);
    step(1);
    check("R8 cal_start on recovery", cs0, 1'b1);
    tick();
    check("R8 muted while calibrating", disc0, 2'b11);
    tick();
    step(1);
    check("R6 R8 reconnect after recovery", disc0, 2'b00);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule